// File: doc/BRIEF.md
# Reset Sequencing Controller

This block turns an external reset request and a memory-wipe select into a stretched reset-out signal, a reset type, a two-bit source code and a set of latched configuration straps. Both external inputs are resynchronized, first on a falling clock edge and then on the following rising edge. A request has to be held for a minimum number of cycles before it counts. Once accepted, the reset is either a master reset, which ends any bus activity and stops memory refresh, or a normal reset, which lets refresh continue so that external memory keeps its contents.

Reset-out is held for the whole request and then for a fixed stretch after the synchronized release. A new request that qualifies during the stretch restarts the sequence and decides the reset type again. The strap inputs are captured when the request is released. Three interrupt lines are registered on each falling edge that still sees the raw request, so they keep the value from the last such edge. An active-low power-on input forces a master reset with its own source code and then runs the same stretch.

Top module: `rst_seq_ctrl`

## Requirements
- R1: The request and wipe inputs are sampled on a falling clock edge and again on the next rising edge. For a request held long enough, rst_out goes high on the seventh rising edge after the first falling edge that sees req_i high.
- R2: A request that stays high for fewer than MIN_HOLD (default 6) synchronized cycles is ignored: rst_out stays low, no terminate pulse occurs and src_code is unchanged. A request of exactly MIN_HOLD cycles is accepted.
- R3: wipe_i is read in the cycle the request is accepted. A value of 1 gives a master reset (rst_type = 1) and a value of 0 gives a normal reset (rst_type = 0). rst_type holds its value until the next accepted reset.
- R4: rst_out stays high through the request and for exactly STRETCH_CYCLES (default 32768) cycles after the synchronized release. It goes low on the (STRETCH_CYCLES+1)-th rising edge after the first falling edge that sees req_i low.
- R5: strap_q loads strap_i on the second rising edge after the first falling edge that sees req_i low. It also follows strap_i while por_n is low. It does not change at any other time.
- R6: term_pulse is high for exactly one cycle when a master reset is accepted, in the same cycle that rst_out rises. It never goes high for a normal reset.
- R7: refresh_abort is high while rst_out is high and the reset is master type, including power-on. It stays low through a whole normal reset and whenever rst_out is low.
- R8: src_code reads 2'b01 after power-on, 2'b11 after an external master reset and 2'b10 after a normal reset. It changes only when a reset is accepted and never reads 2'b00.
- R9: irq_q loads irq_i on each falling edge where req_i is high. After a release it holds the value from the last falling edge on which the request was still seen.
- R10: A request that qualifies during the stretch returns the block to the request phase, decides type and source again, and restarts the full stretch from the new release. A short pulse during the stretch leaves type, source and the stretch unchanged.
- R11: While por_n is low, rst_out = 1, rst_type = 1, src_code = 2'b01, refresh_abort = 1, term_pulse = 0 and irq_q = 0. rst_out goes low on the STRETCH_CYCLES-th rising edge that samples por_n high, counting the first such edge as one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; both edges are used by the synchronizers |
| por_n | input | 1 | Active-low power-on reset, sampled on clock edges |
| req_i | input | 1 | External reset request, active high |
| wipe_i | input | 1 | Master (1) or normal (0) reset select |
| strap_i | input | STRAP_W | Configuration straps |
| irq_i | input | IRQ_W | Interrupt lines captured during the request |
| rst_out | output | 1 | Stretched reset-out |
| term_pulse | output | 1 | One-cycle bus-cycle terminate pulse on a master reset |
| refresh_abort | output | 1 | Stop memory refresh during a master reset |
| rst_type | output | 1 | 1 = master, 0 = normal |
| src_code | output | 2 | Source of the last reset |
| strap_q | output | STRAP_W | Latched straps |
| irq_q | output | IRQ_W | Interrupt lines captured during the request |

## Verification
The release of a request is the cycle where two functions overlap. The falling-edge interrupt capture must keep the value from before the release, while the strap capture and the stretch load happen one rising edge later. The bench changes req_i and irq_i in the same drive step and moves strap_i only after the capture edge. It then checks that irq_q keeps the old value, that strap_q holds the value present at release, and that rst_out falls after exactly the stretch. A second overlap is a request that qualifies while the stretch is counting: this is provoked by a normal reset followed by a master request. The bench judges it by the new type, the new source and the terminate pulse, and by a fall of rst_out timed from the second release.

// File: rtl/rst_seq_pkg.sv
`timescale 1ns/1ps
package rst_seq_pkg;
  typedef enum logic [1:0] {
    PH_IDLE    = 2'd0,
    PH_HOLD    = 2'd1,
    PH_STRETCH = 2'd2
  } phase_t;

  localparam logic [1:0] SRC_POWER  = 2'b01;
  localparam logic [1:0] SRC_NORMAL = 2'b10;
  localparam logic [1:0] SRC_MASTER = 2'b11;
endpackage

// File: rtl/rst_dual_sync.sv
`timescale 1ns/1ps
// Two-stage resynchronizer: falling-edge stage then rising-edge stage, per bit.
module rst_dual_sync #(
  parameter int W = 2
) (
  input  logic         clk,
  input  logic         por_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    logic fall_q;
    logic rise_q;

    always_ff @(negedge clk) begin
      if (!por_n) fall_q <= 1'b0;
      else        fall_q <= d[i];
    end

    always_ff @(posedge clk) begin
      if (!por_n) rise_q <= 1'b0;
      else        rise_q <= fall_q;
    end

    assign q[i] = rise_q;
  end
endmodule

// File: rtl/rst_hold_qual.sv
`timescale 1ns/1ps
// Counts consecutive synchronized request cycles; qual marks the MIN-th one.
module rst_hold_qual #(
  parameter int MIN = 6
) (
  input  logic clk,
  input  logic por_n,
  input  logic req_s,
  output logic qual
);
  localparam int CW = (MIN > 2) ? $clog2(MIN) : 1;
  localparam logic [CW-1:0] LAST = CW'(MIN - 1);

  logic [CW-1:0] run_cnt;

  always_ff @(posedge clk) begin
    if (!por_n || !req_s)   run_cnt <= '0;
    else if (run_cnt != LAST) run_cnt <= run_cnt + 1'b1;
  end

  assign qual = req_s && (run_cnt == LAST);
endmodule

// File: rtl/rst_phase_fsm.sv
`timescale 1ns/1ps
// Phase sequencer: idle, request held, post-release stretch.
module rst_phase_fsm
  import rst_seq_pkg::*;
#(
  parameter int STRETCH = 32768
) (
  input  logic       clk,
  input  logic       por_n,
  input  logic       req_s,
  input  logic       wipe_s,
  input  logic       qual,
  output logic       rst_out,
  output logic       term_pulse,
  output logic       refresh_abort,
  output logic       rst_type,
  output logic [1:0] src_code,
  output logic       cap_strap
);
  localparam int SW = $clog2(STRETCH);
  // release cycle itself counts as the first stretch cycle
  localparam logic [SW-1:0] LOAD_REL = SW'(STRETCH - 2);
  localparam logic [SW-1:0] LOAD_POR = SW'(STRETCH - 1);

  phase_t        phase, nphase;
  logic [SW-1:0] cnt, ncnt;
  logic          ntype;
  logic [1:0]    nsrc;
  logic          nterm;

  always_comb begin
    nphase    = phase;
    ncnt      = cnt;
    ntype     = rst_type;
    nsrc      = src_code;
    nterm     = 1'b0;
    cap_strap = 1'b0;
    case (phase)
      PH_IDLE: begin
        if (qual) begin
          nphase = PH_HOLD;
          ntype  = wipe_s;
          nsrc   = wipe_s ? SRC_MASTER : SRC_NORMAL;
          nterm  = wipe_s;
        end
      end
      PH_HOLD: begin
        if (!req_s) begin
          nphase    = PH_STRETCH;
          ncnt      = LOAD_REL;
          cap_strap = 1'b1;
        end
      end
      PH_STRETCH: begin
        if (qual) begin
          nphase = PH_HOLD;
          ntype  = wipe_s;
          nsrc   = wipe_s ? SRC_MASTER : SRC_NORMAL;
          nterm  = wipe_s;
        end else if (cnt == '0) begin
          nphase = PH_IDLE;
        end else begin
          ncnt = cnt - 1'b1;
        end
      end
      default: nphase = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!por_n) begin
      phase         <= PH_STRETCH;
      cnt           <= LOAD_POR;
      rst_type      <= 1'b1;
      src_code      <= SRC_POWER;
      rst_out       <= 1'b1;
      refresh_abort <= 1'b1;
      term_pulse    <= 1'b0;
    end else begin
      phase         <= nphase;
      cnt           <= ncnt;
      rst_type      <= ntype;
      src_code      <= nsrc;
      rst_out       <= (nphase != PH_IDLE);
      refresh_abort <= (nphase != PH_IDLE) && ntype;
      term_pulse    <= nterm;
    end
  end
endmodule

// File: rtl/rst_capture.sv
`timescale 1ns/1ps
// Strap latch (rising edge) and interrupt capture (falling edge, raw request).
module rst_capture #(
  parameter int STRAP_W = 3,
  parameter int IRQ_W   = 3
) (
  input  logic               clk,
  input  logic               por_n,
  input  logic               req_raw,
  input  logic               cap_strap,
  input  logic [STRAP_W-1:0] strap_i,
  input  logic [IRQ_W-1:0]   irq_i,
  output logic [STRAP_W-1:0] strap_q,
  output logic [IRQ_W-1:0]   irq_q
);
  always_ff @(posedge clk) begin
    if (!por_n || cap_strap) strap_q <= strap_i;
  end

  always_ff @(negedge clk) begin
    if (!por_n)       irq_q <= '0;
    else if (req_raw) irq_q <= irq_i;
  end
endmodule

// File: rtl/rst_seq_ctrl.sv
`timescale 1ns/1ps
module rst_seq_ctrl #(
  parameter int STRETCH_CYCLES = 32768,
  parameter int MIN_HOLD       = 6,
  parameter int STRAP_W        = 3,
  parameter int IRQ_W          = 3
) (
  input  logic               clk,
  input  logic               por_n,
  input  logic               req_i,
  input  logic               wipe_i,
  input  logic [STRAP_W-1:0] strap_i,
  input  logic [IRQ_W-1:0]   irq_i,
  output logic               rst_out,
  output logic               term_pulse,
  output logic               refresh_abort,
  output logic               rst_type,
  output logic [1:0]         src_code,
  output logic [STRAP_W-1:0] strap_q,
  output logic [IRQ_W-1:0]   irq_q
);
  logic [1:0] sync_q;
  logic       req_s, wipe_s, qual, cap_strap;

  rst_dual_sync #(.W(2)) u_sync (
    .clk(clk), .por_n(por_n), .d({wipe_i, req_i}), .q(sync_q)
  );
  assign req_s  = sync_q[0];
  assign wipe_s = sync_q[1];

  rst_hold_qual #(.MIN(MIN_HOLD)) u_qual (
    .clk(clk), .por_n(por_n), .req_s(req_s), .qual(qual)
  );

  rst_phase_fsm #(.STRETCH(STRETCH_CYCLES)) u_fsm (
    .clk(clk), .por_n(por_n), .req_s(req_s), .wipe_s(wipe_s), .qual(qual),
    .rst_out(rst_out), .term_pulse(term_pulse), .refresh_abort(refresh_abort),
    .rst_type(rst_type), .src_code(src_code), .cap_strap(cap_strap)
  );

  rst_capture #(.STRAP_W(STRAP_W), .IRQ_W(IRQ_W)) u_cap (
    .clk(clk), .por_n(por_n), .req_raw(req_i), .cap_strap(cap_strap),
    .strap_i(strap_i), .irq_i(irq_i), .strap_q(strap_q), .irq_q(irq_q)
  );
endmodule

// File: rtl/rst_seq_ctrl_chk.sv
`timescale 1ns/1ps
module rst_seq_ctrl_chk #(
  parameter int STRAP_W = 3
) (
  input logic               clk,
  input logic               por_n,
  input logic               rst_out,
  input logic               term_pulse,
  input logic               refresh_abort,
  input logic               rst_type,
  input logic [1:0]         src_code,
  input logic [STRAP_W-1:0] strap_q
);
  assert_term_master_R6: assert property (@(posedge clk) disable iff (!por_n)
    term_pulse |-> (rst_type && rst_out && src_code == 2'b11));

  assert_term_single_R6: assert property (@(posedge clk) disable iff (!por_n)
    term_pulse |=> !term_pulse);

  assert_abort_type_R7: assert property (@(posedge clk) disable iff (!por_n)
    rst_out |-> (refresh_abort == rst_type));

  assert_abort_idle_R7: assert property (@(posedge clk) disable iff (!por_n)
    !rst_out |-> !refresh_abort);

  assert_src_change_R8: assert property (@(posedge clk) disable iff (!por_n)
    !$stable(src_code) |-> rst_out);

  assert_src_legal_R8: assert property (@(posedge clk) disable iff (!por_n)
    src_code != 2'b00);

  assert_strap_hold_R5: assert property (@(posedge clk) disable iff (!por_n)
    !rst_out |=> $stable(strap_q));
endmodule

bind rst_seq_ctrl rst_seq_ctrl_chk #(.STRAP_W(STRAP_W)) u_chk (
  .clk(clk), .por_n(por_n), .rst_out(rst_out), .term_pulse(term_pulse),
  .refresh_abort(refresh_abort), .rst_type(rst_type), .src_code(src_code),
  .strap_q(strap_q)
);

// File: tb/rst_seq_ctrl_tb.sv
`timescale 1ns/1ps
module rst_seq_ctrl_tb;
  localparam int S = 32768;

  logic       clk = 1'b0;
  logic       por_n, req, wipe;
  logic [2:0] strap, irq;
  logic       rst_out, term_pulse, refresh_abort, rst_type;
  logic [1:0] src_code;
  logic [2:0] strap_q, irq_q;

  int n_chk  = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  rst_seq_ctrl u_dut (
    .clk(clk), .por_n(por_n), .req_i(req), .wipe_i(wipe), .strap_i(strap),
    .irq_i(irq), .rst_out(rst_out), .term_pulse(term_pulse),
    .refresh_abort(refresh_abort), .rst_type(rst_type), .src_code(src_code),
    .strap_q(strap_q), .irq_q(irq_q)
  );

  typedef struct packed {
    logic [3:0] len;
    logic       wipe;
    logic [2:0] strap;
    logic       qual;
  } vec_t;

  localparam vec_t VECS [5] = '{
    '{4'd1, 1'b1, 3'b001, 1'b0},
    '{4'd5, 1'b1, 3'b010, 1'b0},
    '{4'd6, 1'b0, 3'b011, 1'b1},
    '{4'd4, 1'b1, 3'b100, 1'b0},
    '{4'd9, 1'b1, 3'b110, 1'b1}
  };

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=running expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [1:0] exp_src;
    logic [2:0] exp_strap;
    por_n = 1'b0; req = 1'b0; wipe = 1'b0; strap = 3'b101; irq = 3'b000;
    tick(4);
    // R11 power-on state
    chk("R11 rst_out", rst_out, 1);
    chk("R11 rst_type", rst_type, 1);
    chk("R11 src_code", src_code, 2'b01);
    chk("R11 refresh_abort", refresh_abort, 1);
    chk("R11 term_pulse", term_pulse, 0);
    chk("R11 irq_q", irq_q, 0);
    por_n = 1'b1;
    tick(1);
    strap = 3'b000;
    chk("R5 strap tracked in por", strap_q, 3'b101);
    tick(S - 2);
    chk("R11 rst_out before end", rst_out, 1);
    tick(1);
    chk("R11 rst_out after stretch", rst_out, 0);
    chk("R7 refresh_abort idle", refresh_abort, 0);
    chk("R5 strap held", strap_q, 3'b101);
    exp_src = 2'b01;
    exp_strap = 3'b101;
    tick(3);

    // vector table
    for (int i = 0; i < 5; i++) begin
      vec_t v;
      int   lim;
      v = VECS[i];
      req = 1'b1; wipe = v.wipe; strap = v.strap;
      lim = ((int'(v.len) > 7) ? int'(v.len) : 7) + 2;
      for (int k = 1; k <= lim; k++) begin
        tick(1);
        if (k == 6 && v.qual) chk("R1 rst_out not yet", rst_out, 0);
        if (k == 7) begin
          chk("R1 R2 rst_out at accept", rst_out, v.qual);
          chk("R6 term_pulse at accept", term_pulse, v.qual & v.wipe);
        end
        if (k == 8 && v.qual) chk("R6 term_pulse one cycle", term_pulse, 0);
        if (k == int'(v.len)) req = 1'b0;
        if (k == int'(v.len) + 2) strap = ~v.strap;
      end
      if (v.qual) begin
        exp_src = v.wipe ? 2'b11 : 2'b10;
        chk("R8 src_code", src_code, exp_src);
        chk("R3 rst_type", rst_type, v.wipe);
        chk("R7 refresh_abort in reset", refresh_abort, v.wipe);
        tick(int'(v.len) + S - lim);
        chk("R4 rst_out last stretch cycle", rst_out, 1);
        tick(1);
        chk("R4 rst_out after stretch", rst_out, 0);
        chk("R7 refresh_abort after", refresh_abort, 0);
        exp_strap = v.strap;
        chk("R5 strap captured", strap_q, exp_strap);
      end else begin
        chk("R2 short pulse rst_out", rst_out, 0);
        chk("R2 short pulse src_code", src_code, exp_src);
        chk("R5 strap unchanged", strap_q, exp_strap);
      end
      tick(3);
    end

    // directed: normal reset, irq capture at release, re-arm during stretch
    req = 1'b1; wipe = 1'b0; strap = 3'b001; irq = 3'b000;
    tick(3);
    irq = 3'b101;
    tick(1);
    chk("R9 irq captured", irq_q, 3'b101);
    tick(3);
    chk("R6 no term for normal", term_pulse, 0);
    chk("R3 normal type", rst_type, 0);
    tick(3);
    req = 1'b0; irq = 3'b010;
    tick(1);
    chk("R9 irq keeps pre-release value", irq_q, 3'b101);
    tick(3);
    chk("R5 strap at release", strap_q, 3'b001);
    chk("R7 normal keeps refresh", refresh_abort, 0);
    chk("R8 normal src", src_code, 2'b10);
    tick(100);
    req = 1'b1; wipe = 1'b1;
    tick(4);
    req = 1'b0;
    tick(6);
    chk("R10 short pulse in stretch src", src_code, 2'b10);
    chk("R10 short pulse in stretch type", rst_type, 0);
    chk("R10 short pulse in stretch rst_out", rst_out, 1);
    tick(100);
    req = 1'b1; wipe = 1'b1;
    tick(7);
    chk("R10 rearm term", term_pulse, 1);
    chk("R10 rearm src", src_code, 2'b11);
    chk("R10 rearm type", rst_type, 1);
    tick(1);
    chk("R10 rearm refresh_abort", refresh_abort, 1);
    tick(4);
    req = 1'b0;
    tick(S);
    chk("R10 R4 rst_out before new end", rst_out, 1);
    tick(1);
    chk("R10 R4 rst_out after new end", rst_out, 0);
    chk("R9 irq from last request", irq_q, 3'b010);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule